// File: doc/BRIEF.md
# Error Input Delay Qualifier

This block supervises an active-low error line driven by a monitored processor. The line is brought into the clock domain by a two-flop synchronizer. A glitch filter, whose length is set by a debounce code, cleans it. The filtered level must then stay low for a programmable qualification time before the block treats it as a fault. A qualified fault produces one single-cycle pulse and sets a sticky error flag. The flag stays set until a write-one-to-clear strobe arrives.

All timing runs off a 1 ms tick strobe supplied from outside. An 8-bit delay code selects the qualification time through a three-segment piecewise mapping:

- a fine segment in 1 ms steps;
- a middle segment in 2 ms steps;
- a coarse segment in 4 ms steps.

The filtered level is also brought out, so downstream logic can re-check whether the line is still low, for example before it releases a reset. An undriven error line reads low. After reset, such a line therefore qualifies as a fault once the delay has elapsed.

Top module: `err_delay_qual`

## Requirements
- R1: While reset is asserted and on its release, `level_o` is 1, `fault_pulse_o` is 0 and `err_flag_o` is 0.
- R2: For a delay code c from 0 to 31, the fault qualifies on tick number c+1 counted while `level_o` is low.
- R3: For a delay code c from 32 to 63, the fault qualifies on tick number 34 + 2*(c-32).
- R4: For a delay code c from 64 to 255, the fault qualifies on tick number 100 + 4*(c-64).
- R5: If `level_o` returns to 1 before the fault qualifies, the tick count is discarded, and the next low episode counts from zero.
- R6: `fault_pulse_o` is high for exactly one cycle per low episode. It fires again only after `level_o` has been 1.
- R7: A qualified fault sets `err_flag_o`. The flag holds until a cycle with `flag_clr_i` = 1, after which it reads 0.
- R8: When `flag_clr_i` and a qualifying tick fall in the same cycle, the set wins and `err_flag_o` stays 1.
- R9: With a debounce code N > 0, `level_o` takes a new synchronized value only after N consecutive ticks that all see that value. A shorter excursion leaves `level_o` unchanged.
- R10: With a debounce code of 0, `level_o` follows `err_ni` two clock cycles later, without waiting for ticks.
- R11: A low `err_ni` (including an undriven line held low) is the fault level. A high `err_ni` is healthy and never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_ni | input | 1 | Asynchronous error line from the processor, active low |
| tick_i | input | 1 | One-cycle 1 ms timing strobe |
| delay_code_i | input | 8 | Qualification delay code, piecewise mapped to ms |
| deb_code_i | input | DEB_W (4) | Debounce length in ticks, 0 = pass-through |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the error flag |
| level_o | output | 1 | Filtered level of the error line (1 = healthy) |
| fault_pulse_o | output | 1 | One-cycle pulse when a fault qualifies |
| err_flag_o | output | 1 | Sticky error flag |

## Verification
Setting the flag on a qualifying tick and clearing it by software can land in the same clock cycle. The bench provokes this by raising `flag_clr_i` together with the exact tick that completes the delay count. It then judges the outcome by requiring the flag to read 1 afterwards, with the qualification pulse still emitted. A second clear strobe, issued alone, must then bring the flag to 0. Qualification times at each end of every mapping segment are compared against a tick-indexed scoreboard.

// File: rtl/err_delay_qual_pkg.sv
package err_delay_qual_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned SEG1_END  = 32;   // first code of the 2 ms segment
  localparam int unsigned SEG2_END  = 64;   // first code of the 4 ms segment
  localparam int unsigned SEG2_BASE = 34;
  localparam int unsigned SEG3_BASE = 100;
  localparam int unsigned DLY_MAX   = SEG3_BASE + 4 * ((1 << CODE_W) - 1 - SEG2_END);
  localparam int unsigned DLY_W     = $clog2(DLY_MAX + 1);

  function automatic logic [DLY_W-1:0] code_to_ms(input logic [CODE_W-1:0] code);
    int unsigned c;
    int unsigned v;
    c = 32'(code);
    if (c < SEG1_END)      v = c + 1;
    else if (c < SEG2_END) v = SEG2_BASE + 2 * (c - SEG1_END);
    else                   v = SEG3_BASE + 4 * (c - SEG2_END);
    return DLY_W'(v);
  endfunction
endpackage

// File: rtl/edq_sync.sv
module edq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= (i == 0) ? d_i : stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/edq_debounce.sv
module edq_debounce #(
  parameter int unsigned DEB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DEB_W-1:0] code_i,
  input  logic             d_i,
  output logic             level_o
);
  logic             filt_q;
  logic [DEB_W-1:0] cnt_q;
  logic             pass;
  logic             done;

  assign pass = (code_i == '0);
  assign done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, code_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pass) begin
      filt_q <= d_i;  // track so a later code change starts clean
      cnt_q  <= '0;
    end else if (d_i == filt_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (done) begin
        filt_q <= d_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = pass ? d_i : filt_q;
endmodule

// File: rtl/edq_timer.sv
module edq_timer
  import err_delay_qual_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             level_i,
  input  logic [DLY_W-1:0] target_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             armed_q;

  // >= so that a shortened code mid-episode fires on the next tick
  assign fire_o = tick_i && !level_i && armed_q &&
                  (({1'b0, cnt_q} + 1'b1) >= {1'b0, target_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (level_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (fire_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick_i && armed_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/err_delay_qual.sv
module err_delay_qual
  import err_delay_qual_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic [DEB_W-1:0]  deb_code_i,
  input  logic              flag_clr_i,
  output logic              level_o,
  output logic              fault_pulse_o,
  output logic              err_flag_o
);
  logic             sync_lvl;
  logic             filt_lvl;
  logic [DLY_W-1:0] target;
  logic             fire;
  logic             pulse_q;
  logic             flag_q;

  edq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (err_ni),
    .q_o    (sync_lvl)
  );

  edq_debounce #(.DEB_W(DEB_W)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .code_i  (deb_code_i),
    .d_i     (sync_lvl),
    .level_o (filt_lvl)
  );

  assign target = code_to_ms(delay_code_i);

  edq_timer u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .level_i  (filt_lvl),
    .target_i (target),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)            flag_q <= 1'b1;  // set beats clear
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign level_o       = filt_lvl;
  assign fault_pulse_o = pulse_q;
  assign err_flag_o    = flag_q;
endmodule

// File: rtl/err_delay_qual_chk.sv
module err_delay_qual_chk #(
  parameter int unsigned DEB_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             err_ni,
  input logic             tick_i,
  input logic [DEB_W-1:0] deb_code_i,
  input logic             flag_clr_i,
  input logic             level_o,
  input logic             fault_pulse_o,
  input logic             err_flag_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |=> !fault_pulse_o);

  a_r7_pulse_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |-> err_flag_o);

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !flag_clr_i) |=> err_flag_o);

  a_r7_set_needs_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> fault_pulse_o);

  a_r8_clear_or_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> (!err_flag_o || fault_pulse_o));

  a_r11_pulse_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && fault_pulse_o) |-> !$past(level_o));

  a_r9_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && deb_code_i != '0 && $past(deb_code_i) != '0 && !$past(tick_i))
      |-> $stable(level_o));

  // assumes the default two-stage synchronizer
  a_r10_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && deb_code_i == '0) |-> (level_o == $past(err_ni, 2)));
endmodule

bind err_delay_qual err_delay_qual_chk #(.DEB_W(DEB_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .err_ni        (err_ni),
  .tick_i        (tick_i),
  .deb_code_i    (deb_code_i),
  .flag_clr_i    (flag_clr_i),
  .level_o       (level_o),
  .fault_pulse_o (fault_pulse_o),
  .err_flag_o    (err_flag_o)
);

// File: tb/err_delay_qual_test.sv
module err_delay_qual_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB_W      = 4;

  typedef struct {
    string req;
    int    at_tick;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             err_ni = 1'b0;
  logic             tick_i = 1'b0;
  logic [7:0]       delay_code_i = '0;
  logic [DEB_W-1:0] deb_code_i = '0;
  logic             flag_clr_i = 1'b0;
  logic             level_o, fault_pulse_o, err_flag_o;

  int   checks = 0;
  int   fails = 0;
  int   tick_no = 0;
  int   ep_pulses = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  err_delay_qual #(.DEB_W(DEB_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_ni(err_ni), .tick_i(tick_i),
    .delay_code_i(delay_code_i), .deb_code_i(deb_code_i), .flag_clr_i(flag_clr_i),
    .level_o(level_o), .fault_pulse_o(fault_pulse_o), .err_flag_o(err_flag_o)
  );

  function automatic int ms_of(input int c);
    if (c >= 64) return 4 * c - 156;
    if (c >= 32) return 2 * c - 30;
    return c + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) tick_i = 1'b1; tick_no++;
    @(negedge clk_i) tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_err(input logic v);
    @(negedge clk_i) err_ni = v;
    repeat (3) @(negedge clk_i);
    tick_no = 0;
    ep_pulses = 0;
  endtask

  task automatic push(input string req, input int at);
    exp_t e;
    e.req = req;
    e.at_tick = at;
    exp_q.push_back(e);
  endtask

  task automatic clear_flag(input string req);
    @(negedge clk_i) flag_clr_i = 1'b1;
    @(negedge clk_i) flag_clr_i = 1'b0;
    chk(err_flag_o == 1'b0, req, int'(err_flag_o), 0);
  endtask

  task automatic episode(input int code, input string req);
    delay_code_i = 8'(code);
    set_err(1'b0);
    push(req, ms_of(code));
    ticks(ms_of(code) + 3);
    chk(ep_pulses == 1, "R6 one pulse per episode", ep_pulses, 1);
    chk(err_flag_o == 1'b1, "R7 flag set", int'(err_flag_o), 1);
    clear_flag("R7 flag cleared");
    set_err(1'b1);
  endtask

  // monitor: pops the scoreboard on each pulse
  initial forever begin
    @(posedge clk_i);
    #1;
    if (fault_pulse_o) begin
      ep_pulses++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected pulse", tick_no, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(tick_no == e.at_tick, e.req, tick_no, e.at_tick);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state with an undriven (low) line
    repeat (3) @(negedge clk_i);
    chk(level_o == 1'b1, "R1 level in reset", int'(level_o), 1);
    chk(fault_pulse_o == 1'b0, "R1 pulse in reset", int'(fault_pulse_o), 0);
    chk(err_flag_o == 1'b0, "R1 flag in reset", int'(err_flag_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(level_o == 1'b1 && err_flag_o == 1'b0, "R1 after release", int'(level_o), 1);

    // R11 undriven low line faults after delay (code 0 -> 1 tick)
    repeat (3) @(negedge clk_i);
    tick_no = 0;
    ep_pulses = 0;
    chk(level_o == 1'b0, "R11 low line seen", int'(level_o), 0);
    push("R11 default fault", 1);
    ticks(3);
    chk(ep_pulses == 1, "R11 one pulse", ep_pulses, 1);
    clear_flag("R7 clear after default fault");
    set_err(1'b1);
    ticks(5);
    chk(ep_pulses == 0 && err_flag_o == 1'b0, "R11 high is healthy", ep_pulses, 0);

    // segment ends
    episode(0,   "R2 code 0");
    episode(31,  "R2 code 31");
    episode(32,  "R3 code 32");
    episode(33,  "R3 code 33");
    episode(63,  "R3 code 63");
    episode(64,  "R4 code 64");
    episode(65,  "R4 code 65");
    episode(255, "R4 code 255");

    // R5 restart on early return high
    delay_code_i = 8'd9;
    set_err(1'b0);
    ticks(8);
    set_err(1'b1);
    ticks(2);
    set_err(1'b0);
    push("R5 restart count", 10);
    ticks(12);
    chk(ep_pulses == 1, "R5 single pulse after restart", ep_pulses, 1);
    clear_flag("R7 clear after R5");
    set_err(1'b1);

    // R8 clear in the firing cycle
    delay_code_i = 8'd2;
    set_err(1'b0);
    push("R8 pulse with clear", 3);
    ticks(2);
    @(negedge clk_i) tick_i = 1'b1; flag_clr_i = 1'b1; tick_no++;
    @(negedge clk_i) tick_i = 1'b0; flag_clr_i = 1'b0;
    chk(err_flag_o == 1'b1, "R8 set wins", int'(err_flag_o), 1);
    repeat (2) @(negedge clk_i);
    clear_flag("R8 later clear");
    set_err(1'b1);

    // R9 debounce of 3 ticks
    delay_code_i = 8'd0;
    deb_code_i = 4'd3;
    set_err(1'b0);
    ticks(2);
    chk(level_o == 1'b1, "R9 short low ignored", int'(level_o), 1);
    set_err(1'b1);
    ticks(2);
    chk(ep_pulses == 0 && level_o == 1'b1, "R9 glitch no fault", int'(level_o), 1);
    set_err(1'b0);
    ticks(2);
    chk(level_o == 1'b1, "R9 two of three ticks", int'(level_o), 1);
    tick();
    chk(level_o == 1'b0, "R9 third tick", int'(level_o), 0);
    tick_no = 0;
    ep_pulses = 0;
    push("R9 fault after debounce", 1);
    ticks(2);
    set_err(1'b1);
    chk(level_o == 1'b0, "R9 high not yet taken", int'(level_o), 0);
    ticks(3);
    chk(level_o == 1'b1, "R9 high after three ticks", int'(level_o), 1);
    clear_flag("R7 clear after R9");

    // R10 pass-through latency
    deb_code_i = 4'd0;
    repeat (2) @(negedge clk_i);
    @(negedge clk_i) err_ni = 1'b0;
    @(negedge clk_i);
    chk(level_o == 1'b1, "R10 one cycle", int'(level_o), 1);
    @(negedge clk_i);
    chk(level_o == 1'b0, "R10 two cycles", int'(level_o), 0);
    @(negedge clk_i) err_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(level_o == 1'b1, "R10 back high", int'(level_o), 1);

    chk(exp_q.size() == 0, "R6 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule